// File: doc/BRIEF.md
# SPI Buffer and Interrupt Front End

This block is the register-side half of an SPI controller. It owns the transmit and receive word buffers, the sticky status flags, and the interrupt outputs. A processor reaches it through a small byte-addressed register port with a control register, a status register, a data register and a buffer control register. On the other side, a serial engine, which is not part of this block, takes words from the transmit buffer and returns the words it received.

Software fills the transmit buffer by writing the data register and drains the receive buffer by reading it. The data register works in one of two widths: byte access carries only the low eight bits, and word access carries the full data width. Each buffer has its own software-set trigger threshold, and the threshold decides when the transmit-low and receive-high flags assert. The receive, transmit and error interrupts each gate a status condition with its own enable bit. A fourth line combines the receive and transmit interrupts.

Register map: offset 0 is control, offset 1 is status, offset 2 is data, and offset 3 is buffer control. Each buffer holds `DEPTH` entries, 32 by default.

Top module: `spibuf_core`

## Requirements
- R1: After reset, control reads 0x00, buffer control reads 0x00, status reads 0x60, all four interrupt outputs are low, and no transmit word is offered to the engine.
- R2: Buffer control bit 3 selects word access (1) or byte access (0). A data write pushes one entry: the full data in word access, the low byte zero-extended in byte access. A data read pops one entry and returns it the same way. A read from an empty buffer returns 0.
- R3: A data write to a full transmit buffer is dropped. The engine then receives the first DEPTH words, in write order.
- R4: Status bit 5 (transmit low) is 1 exactly when the transmit fill level is at most code × DEPTH/4, where code is buffer control bits 5:4.
- R5: Status bit 7 (receive high) is 1 exactly when the receive fill level is at least the receive threshold. With code = buffer control bits 2:0, the threshold is 1 for code 0 and code × DEPTH/8 otherwise.
- R6: A received word arriving when the receive buffer is full is discarded and sets status bit 0 (overrun). The flag clears only when software writes 0 to status bit 0. Writing 1 to that bit leaves it unchanged.
- R7: With control bit 1 (transmit-only) set, received words are not stored, status bit 7 stays 0, and overrun is not raised.
- R8: Buffer control bit 7 empties the transmit buffer and bit 6 empties the receive buffer. Each buffer stays empty, ignoring pushes, for as long as its bit holds 1.
- R9: The receive interrupt is status bit 7 AND control bit 7. The transmit interrupt is status bit 5 AND control bit 5. The error interrupt is control bit 4 AND (status bit 0 OR bit 2 OR bit 3). The combined line is the OR of the receive and transmit interrupts.
- R10: A transmit word is offered to the engine only while control bit 6 (function enable) is 1 and the transmit buffer is non-empty. Received words are stored only while function enable is 1.
- R11: An engine parity-error pulse sets status bit 3 and a mode-fault pulse sets status bit 2. Each flag clears only when software writes 0 to its bit.
- R12: Status bit 1 reflects the engine busy input. Status bit 6 (transmit end) is 1 exactly when the transmit buffer is empty and the engine is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive buffer at offset 2) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| eng_tx_valid | output | 1 | A transmit word is available to the engine |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine takes the offered word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_perr | input | 1 | Parity error pulse |
| eng_modf | input | 1 | Mode fault pulse |
| eng_busy | input | 1 | Engine is shifting |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_any | output | 1 | Receive or transmit interrupt |

## Verification
The assertions assume that the engine pulses `eng_tx_pop` only while `eng_tx_valid` is high, and that `bus_wr` and `bus_rd` are never raised in the same cycle. The stimulus meets both conditions: it pops only after it has seen the valid flag, and it drives one bus strobe per task. The stimulus also never reads the data register in the same cycle that the engine delivers a word into a full receive buffer. Because of this, the moment an overrun occurs depends only on the fill level, not on how a pop and a push are ordered within one cycle.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_STAT = 2'd1,
      RA_DATA = 2'd2,
      RA_BUF  = 2'd3
   } reg_addr_e;

   // control register, bit 7 down to bit 0
   typedef struct packed {
      logic rx_ie;
      logic fn_en;
      logic tx_ie;
      logic err_ie;
      logic master;
      logic mf_en;
      logic tx_only;
      logic three_wire;
   } ctrl_t;

   // buffer control register, bit 7 down to bit 0
   typedef struct packed {
      logic       tx_clr;
      logic       rx_clr;
      logic [1:0] tx_code;
      logic       wide;
      logic [2:0] rx_code;
   } bufctl_t;

   localparam int IRQ_RX  = 0;
   localparam int IRQ_TX  = 1;
   localparam int IRQ_ERR = 2;
   localparam int IRQ_N   = 3;

endpackage

// File: rtl/spibuf_fifo.sv
module spibuf_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spibuf_fifo: DEPTH must be a power of two, at least 8");
      end
      if (W < 1) begin : g_bad_width
         $error("spibuf_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !clr;
   assign do_pop  = pop && !empty && !clr;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + PW'(1);
         if (do_pop)  rptr <= rptr + PW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R3
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> (full && dout == $past(dout))); // R3
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty); // R8

endmodule

// File: rtl/spibuf_level.sv
module spibuf_level #(
   parameter int DEPTH = 32,
   parameter int CW    = 6
) (
   input  logic [CW-1:0] tx_count,
   input  logic [CW-1:0] rx_count,
   input  logic [1:0]    tx_code,
   input  logic [2:0]    rx_code,
   output logic          tx_low,
   output logic          rx_high
);

   localparam int TX_STEP = DEPTH / 4;
   localparam int RX_STEP = DEPTH / 8;

   generate
      if (RX_STEP < 1 || (1 << (CW - 1)) < DEPTH) begin : g_bad_level
         $error("spibuf_level: DEPTH and CW are inconsistent");
      end
   endgenerate

   logic [CW-1:0] tx_thr, rx_thr;

   always_comb begin
      tx_thr = CW'(tx_code) * CW'(TX_STEP);
      if (rx_code == 3'd0) rx_thr = CW'(1);
      else                 rx_thr = CW'(rx_code) * CW'(RX_STEP);
      tx_low  = (tx_count <= tx_thr);
      rx_high = (rx_count >= rx_thr);
   end

endmodule

// File: rtl/spibuf_irq.sv
module spibuf_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond,
   input  logic [N-1:0] en,
   output logic [N-1:0] irq
);

   generate
      if (N < 1) begin : g_bad_n
         $error("spibuf_irq: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_line
         assign irq[i] = cond[i] & en[i];
         AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> !irq[i]); // R9
      end
   endgenerate

endmodule

// File: rtl/spibuf_core.sv
module spibuf_core
   import spibuf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 2,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              eng_tx_valid,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_tx_pop,
   input  logic              eng_rx_valid,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              eng_perr,
   input  logic              eng_modf,
   input  logic              eng_busy,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_err,
   output logic              irq_any
);

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("spibuf_core: DATA_W must be at least 8");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("spibuf_core: ADDR_W must be at least 2");
      end
   endgenerate

   ctrl_t   ctl;
   bufctl_t bctl;
   logic    ovr, perr, modf;

   logic sel_ctrl, sel_stat, sel_data, sel_buf;
   logic wr_ctrl, wr_stat, wr_data, wr_buf, rd_data;

   assign sel_ctrl = (bus_addr == ADDR_W'(RA_CTRL));
   assign sel_stat = (bus_addr == ADDR_W'(RA_STAT));
   assign sel_data = (bus_addr == ADDR_W'(RA_DATA));
   assign sel_buf  = (bus_addr == ADDR_W'(RA_BUF));
   assign wr_ctrl  = bus_wr && sel_ctrl;
   assign wr_stat  = bus_wr && sel_stat;
   assign wr_data  = bus_wr && sel_data;
   assign wr_buf   = bus_wr && sel_buf;
   assign rd_data  = bus_rd && sel_data;

   // transmit path
   logic [DATA_W-1:0] tx_din, tx_dout;
   logic [CW-1:0]     tx_count;
   logic              tx_full, tx_empty, tx_pop;

   assign tx_din       = bctl.wide ? bus_wdata : {{(DATA_W-8){1'b0}}, bus_wdata[7:0]};
   assign eng_tx_valid = ctl.fn_en && !tx_empty && !bctl.tx_clr;
   assign eng_tx_data  = tx_dout;
   assign tx_pop       = eng_tx_pop && eng_tx_valid;

   spibuf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bctl.tx_clr),
      .push  (wr_data),
      .din   (tx_din),
      .pop   (tx_pop),
      .dout  (tx_dout),
      .count (tx_count),
      .full  (tx_full),
      .empty (tx_empty)
   );

   // receive path
   logic [DATA_W-1:0] rx_dout;
   logic [CW-1:0]     rx_count;
   logic              rx_full, rx_empty, rx_accept, rx_push, ovr_set;

   assign rx_accept = eng_rx_valid && ctl.fn_en && !ctl.tx_only && !bctl.rx_clr;
   assign rx_push   = rx_accept && !rx_full;
   assign ovr_set   = rx_accept && rx_full;

   spibuf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bctl.rx_clr),
      .push  (rx_push),
      .din   (eng_rx_data),
      .pop   (rd_data),
      .dout  (rx_dout),
      .count (rx_count),
      .full  (rx_full),
      .empty (rx_empty)
   );

   // thresholds
   logic tx_low, rx_high_raw, rx_high, tx_end;

   spibuf_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
      .tx_count (tx_count),
      .rx_count (rx_count),
      .tx_code  (bctl.tx_code),
      .rx_code  (bctl.rx_code),
      .tx_low   (tx_low),
      .rx_high  (rx_high_raw)
   );

   assign rx_high = rx_high_raw && !ctl.tx_only;
   assign tx_end  = tx_empty && !eng_busy;

   // registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         bctl <= '0;
      end else begin
         if (wr_ctrl) ctl  <= ctrl_t'(bus_wdata[7:0]);
         if (wr_buf)  bctl <= bufctl_t'(bus_wdata[7:0]);
      end
   end

   // error flags: set by events, cleared by writing 0, writing 1 keeps them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr  <= 1'b0;
         perr <= 1'b0;
         modf <= 1'b0;
      end else begin
         if (ovr_set)                        ovr  <= 1'b1;
         else if (wr_stat && !bus_wdata[0])  ovr  <= 1'b0;
         if (eng_perr)                       perr <= 1'b1;
         else if (wr_stat && !bus_wdata[3])  perr <= 1'b0;
         if (eng_modf)                       modf <= 1'b1;
         else if (wr_stat && !bus_wdata[2])  modf <= 1'b0;
      end
   end

   logic [7:0] status;
   assign status = {rx_high, tx_end, tx_low, 1'b0, perr, modf, eng_busy, ovr};

   // read mux
   logic [DATA_W-1:0] rx_word;
   always_comb begin
      if (rx_empty)       rx_word = '0;
      else if (bctl.wide) rx_word = rx_dout;
      else                rx_word = {{(DATA_W-8){1'b0}}, rx_dout[7:0]};
      unique case (1'b1)
         sel_ctrl: bus_rdata = {{(DATA_W-8){1'b0}}, ctl};
         sel_stat: bus_rdata = {{(DATA_W-8){1'b0}}, status};
         sel_data: bus_rdata = rx_word;
         sel_buf:  bus_rdata = {{(DATA_W-8){1'b0}}, bctl};
         default:  bus_rdata = '0;
      endcase
   end

   // interrupts
   logic [IRQ_N-1:0] irq_cond, irq_en, irq_vec;
   assign irq_cond[IRQ_RX]  = rx_high;
   assign irq_cond[IRQ_TX]  = tx_low;
   assign irq_cond[IRQ_ERR] = ovr | perr | modf;
   assign irq_en[IRQ_RX]    = ctl.rx_ie;
   assign irq_en[IRQ_TX]    = ctl.tx_ie;
   assign irq_en[IRQ_ERR]   = ctl.err_ie;

   spibuf_irq #(.N(IRQ_N)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (irq_cond),
      .en    (irq_en),
      .irq   (irq_vec)
   );

   assign irq_rx  = irq_vec[IRQ_RX];
   assign irq_tx  = irq_vec[IRQ_TX];
   assign irq_err = irq_vec[IRQ_ERR];
   assign irq_any = irq_rx | irq_tx;

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !(wr_stat && !bus_wdata[0])) |=> ovr); // R6
   AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (perr && !(wr_stat && !bus_wdata[3])) |=> perr); // R11
   AST_TXONLY_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.tx_only && !wr_ctrl) |=> (rx_count <= $past(rx_count))); // R7
   AST_TEND_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end |-> !eng_tx_valid); // R12
   AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      eng_tx_pop |-> eng_tx_valid); // R10

endmodule

// File: tb/spibuf_core_bench.sv
module spibuf_core_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int DEPTH = 32;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [1:0]    bus_addr = '0;
   logic          bus_wr = 0, bus_rd = 0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          eng_tx_valid;
   logic [DW-1:0] eng_tx_data;
   logic          eng_tx_pop = 0, eng_rx_valid = 0;
   logic [DW-1:0] eng_rx_data = '0;
   logic          eng_perr = 0, eng_modf = 0, eng_busy = 0;
   logic          irq_rx, irq_tx, irq_err, irq_any;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spibuf_core #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(2)) u_spibuf_core (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid),
      .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop), .eng_rx_valid(eng_rx_valid),
      .eng_rx_data(eng_rx_data), .eng_perr(eng_perr), .eng_modf(eng_modf),
      .eng_busy(eng_busy), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err),
      .irq_any(irq_any)
   );

   // receive threshold table: {code, words pushed, expected status bit 7}
   localparam logic [10:0] RX_VEC [9] = '{
      {3'd0, 7'd0,  1'b0}, {3'd0, 7'd1,  1'b1}, {3'd1, 7'd3,  1'b0},
      {3'd1, 7'd4,  1'b1}, {3'd2, 7'd7,  1'b0}, {3'd2, 7'd8,  1'b1},
      {3'd4, 7'd16, 1'b1}, {3'd7, 7'd27, 1'b0}, {3'd7, 7'd28, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic rx_in(input logic [DW-1:0] d);
      @(negedge clk); eng_rx_data = d; eng_rx_valid = 1;
      @(negedge clk); eng_rx_valid = 0;
   endtask

   task automatic tx_out(output logic [DW-1:0] d, output logic v);
      @(negedge clk); v = eng_tx_valid; d = eng_tx_data;
      eng_tx_pop = v;
      @(negedge clk); eng_tx_pop = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [DW-1:0] d;
      logic v;
      do_reset();

      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl", d, 16'h00);
      rd(2'd1, d); chk("R1 status", d, 16'h60);
      rd(2'd3, d); chk("R1 bufctl", d, 16'h00);
      chk("R1 irqs", {irq_rx, irq_tx, irq_err, irq_any}, 4'b0);
      chk("R1 no offer", eng_tx_valid, 1'b0);

      // R5 receive threshold table
      wr(2'd0, 16'h40);
      foreach (RX_VEC[i]) begin
         wr(2'd3, 16'h40);
         wr(2'd3, {8'h0, 4'b0000, 1'b1, RX_VEC[i][10:8]});
         for (int k = 0; k < int'(RX_VEC[i][7:1]); k++) rx_in(DW'(k));
         rd(2'd1, d);
         chk("R5 rx high", d[7], RX_VEC[i][0]);
      end

      // R2 access width
      do_reset();
      wr(2'd0, 16'h40); wr(2'd3, 16'h08);
      wr(2'd2, 16'hA5C3); tx_out(d, v);
      chk("R2 word write", {v, d}, {1'b1, 16'hA5C3});
      wr(2'd3, 16'h00);
      wr(2'd2, 16'hA5C3); tx_out(d, v);
      chk("R2 byte write", {v, d}, {1'b1, 16'h00C3});
      rx_in(16'h1234); rd(2'd2, d);
      chk("R2 byte read", d, 16'h0034);
      rd(2'd2, d); chk("R2 empty read", d, 16'h0000);

      // R10 / R3 offer gating and full-buffer drop
      do_reset();
      wr(2'd3, 16'h08);
      for (int i = 0; i <= DEPTH; i++) wr(2'd2, DW'(16'h200 + i));
      chk("R10 no offer when disabled", eng_tx_valid, 1'b0);
      wr(2'd0, 16'h40);
      for (int i = 0; i < DEPTH; i++) begin
         tx_out(d, v);
         chk("R3 order", {v, d}, {1'b1, DW'(16'h200 + i)});
      end
      chk("R3 extra dropped", eng_tx_valid, 1'b0);

      // R4 / R9 transmit threshold and interrupt
      do_reset();
      wr(2'd3, 16'h18);
      for (int i = 0; i < 8; i++) wr(2'd2, DW'(i));
      rd(2'd1, d); chk("R4 at threshold", d[5], 1'b1);
      wr(2'd2, 16'h8);
      rd(2'd1, d); chk("R4 above threshold", d[5], 1'b0);
      wr(2'd0, 16'h20);
      chk("R9 tx irq off", {irq_tx, irq_any}, 2'b00);
      wr(2'd0, 16'h60); tx_out(d, v);
      chk("R9 tx irq on", {irq_tx, irq_any}, 2'b11);

      // R6 overrun
      do_reset();
      wr(2'd3, 16'h08); wr(2'd0, 16'h50);
      for (int i = 0; i < DEPTH; i++) rx_in(DW'(16'h100 + i));
      rd(2'd1, d); chk("R6 full no ovr", d[0], 1'b0);
      rx_in(16'hDEAD);
      rd(2'd1, d); chk("R6 ovr status", d, 16'hE1);
      chk("R9 err irq", irq_err, 1'b1);
      wr(2'd1, 16'hFF); rd(2'd1, d); chk("R6 write 1 keeps", d[0], 1'b1);
      wr(2'd1, 16'hFE); rd(2'd1, d); chk("R6 write 0 clears", d[0], 1'b0);
      chk("R9 err irq cleared", irq_err, 1'b0);
      rd(2'd2, d); chk("R6 first word", d, 16'h100);
      for (int i = 1; i < DEPTH - 1; i++) rd(2'd2, d);
      rd(2'd2, d); chk("R6 last word kept", d, 16'h11F);
      rd(2'd1, d); chk("R6 drained", d[7], 1'b0);

      // R7 transmit-only
      do_reset();
      wr(2'd3, 16'h08); wr(2'd0, 16'h42);
      rx_in(16'h55AA); rx_in(16'h55AB);
      rd(2'd1, d); chk("R7 no rx flag", d[7], 1'b0);
      chk("R7 no overrun", d[0], 1'b0);
      wr(2'd0, 16'h40);
      rd(2'd2, d); chk("R7 nothing stored", d, 16'h0);

      // R8 buffer resets
      do_reset();
      wr(2'd3, 16'h08); wr(2'd0, 16'h40);
      wr(2'd2, 16'h11); wr(2'd2, 16'h22);
      chk("R8 offered", eng_tx_valid, 1'b1);
      wr(2'd3, 16'h88);
      chk("R8 tx cleared", eng_tx_valid, 1'b0);
      wr(2'd2, 16'h77);
      wr(2'd3, 16'h08);
      chk("R8 push ignored while held", eng_tx_valid, 1'b0);
      rx_in(16'h33);
      wr(2'd3, 16'h48); rx_in(16'h44); wr(2'd3, 16'h08);
      rd(2'd2, d); chk("R8 rx cleared", d, 16'h0);

      // R11 parity and mode fault
      do_reset();
      wr(2'd0, 16'h10);
      @(negedge clk); eng_perr = 1; @(negedge clk); eng_perr = 0;
      rd(2'd1, d); chk("R11 parity set", d[3], 1'b1);
      chk("R11 err irq", irq_err, 1'b1);
      @(negedge clk); eng_modf = 1; @(negedge clk); eng_modf = 0;
      wr(2'd1, 16'hF7);
      rd(2'd1, d); chk("R11 selective clear", d[3:2], 2'b01);

      // R12 busy and transmit end
      do_reset();
      @(negedge clk); eng_busy = 1;
      rd(2'd1, d); chk("R12 busy status", d, 16'h22);
      @(negedge clk); eng_busy = 0;
      rd(2'd1, d); chk("R12 idle status", d, 16'h60);

      // R9 receive interrupt
      wr(2'd0, 16'hC0); rx_in(16'h5);
      chk("R9 rx irq", {irq_rx, irq_any}, 2'b11);
      rd(2'd2, d);
      chk("R9 rx irq after read", irq_rx, 1'b0);

      finish_run();
   end

endmodule